// File: doc/BRIEF.md
# Semaphore-Tagged Counter Register

This block holds a single value of a configurable width, from 1 to 64 bits. Each clock cycle it can load new data through a write port. Through a small command field it can also clear the value, count it up by one or count it down by one. Beside the value it keeps a one-bit "fresh data" flag. Every data load raises the flag, and only an explicit acknowledge command lowers it. A consumer can therefore tell when a new value has arrived, read it, and then acknowledge it.

Internally the block has three parts:

- A command decoder turns the write strobe and the command code into one datapath action.
- The value register carries out that action.
- A two-state flag machine tracks the fresh flag. Its states are `SEM_EMPTY` (no unacknowledged data) and `SEM_FRESH` (data written, not yet acknowledged). It has three named transitions:
  - `T_ARRIVE`: a write moves `SEM_EMPTY` to `SEM_FRESH`.
  - `T_ACK`: an acknowledge without a write moves `SEM_FRESH` to `SEM_EMPTY`.
  - `T_HOLD`: any other input leaves the state unchanged.

A synchronous reset returns the flag machine to `SEM_EMPTY`. All state changes take effect on the rising clock edge, and the outputs come straight from registers.

Top module: `semtag_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `value` = 0 and `fresh` = 0.
- R2: When `wr_en` = 1, the next `value` equals `wr_data` and the next `fresh` is 1.
- R3: Command code 3'd1 (zero), without a write, sets `value` to 0 and leaves `fresh` unchanged.
- R4: Command code 3'd2 (count up), without a write, adds one to `value` modulo 2^WIDTH, so the all-ones value becomes 0.
- R5: Command code 3'd3 (count down), without a write, subtracts one from `value` modulo 2^WIDTH, so 0 becomes all-ones.
- R6: Command code 3'd4 (acknowledge), without a write, clears `fresh` and leaves `value` unchanged.
- R7: A write in the same cycle as command 3'd1, 3'd2 or 3'd3 loads `wr_data`. The command is ignored.
- R8: A write in the same cycle as command 3'd4 leaves `fresh` at 1.
- R9: Command code 3'd0 and the unused codes 3'd5 to 3'd7, without a write, change neither `value` nor `fresh`.
- R10: No command other than 3'd4 ever clears `fresh`, and none of them sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Load `wr_data` this cycle |
| wr_data | input | WIDTH | Data to load |
| cmd | input | 3 | Command code: 0 none, 1 zero, 2 up, 3 down, 4 acknowledge, 5-7 none |
| value | output | WIDTH | Registered stored value |
| fresh | output | 1 | Registered fresh-data flag |

## Verification
The assertions assume that `wr_en`, `wr_data` and `cmd` are known (not X) at every rising edge outside reset. They also assume that the first edge comes with `rst` high, so that no `$past` comparison reaches back before a defined state. The bench drives every input from a defined value at falling edges and holds reset for the first cycles. Its random stimulus draws all eight command codes and both write states. It also drives data values at and near zero and all-ones, so that counting across both wrap points and every priority pairing come up inside those assumptions.

// File: rtl/semtag_pkg.sv
package semtag_pkg;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_ZERO = 3'd1,
        CMD_UP   = 3'd2,
        CMD_DOWN = 3'd3,
        CMD_ACK  = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_ZERO,
        ACT_UP,
        ACT_DOWN
    } act_e;

    typedef enum logic {
        SEM_EMPTY = 1'b0,
        SEM_FRESH = 1'b1
    } sem_e;

endpackage

// File: rtl/semtag_decode.sv
module semtag_decode
    import semtag_pkg::*;
(
    input  logic       wr_en,
    input  logic [2:0] cmd,
    output act_e       act,
    output logic       flag_set,
    output logic       flag_ack
);

    always_comb begin
        act      = ACT_HOLD;
        flag_set = wr_en;
        flag_ack = 1'b0;
        if (wr_en) begin
            act = ACT_LOAD;
        end else begin
            unique case (cmd)
                CMD_ZERO: act = ACT_ZERO;
                CMD_UP:   act = ACT_UP;
                CMD_DOWN: act = ACT_DOWN;
                CMD_ACK:  flag_ack = 1'b1;
                default:  act = ACT_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/semtag_value.sv
module semtag_value
    import semtag_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  act_e             act,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= ZERO;
        end else begin
            unique case (act)
                ACT_LOAD: q <= wr_data;
                ACT_ZERO: q <= ZERO;
                ACT_UP:   q <= q + STEP;
                ACT_DOWN: q <= q - STEP;
                default:  q <= q;
            endcase
        end
    end

    // R4 / R5: counting wraps modulo 2^WIDTH
    a_r4_up_wraps: assert property (@(posedge clk) disable iff (rst)
        act == ACT_UP |=> q == $past(q) + STEP);
    a_r5_down_wraps: assert property (@(posedge clk) disable iff (rst)
        act == ACT_DOWN |=> q == $past(q) - STEP);
    a_r3_zero_clears: assert property (@(posedge clk) disable iff (rst)
        act == ACT_ZERO |=> q == ZERO);

endmodule

// File: rtl/semtag_flag.sv
module semtag_flag
    import semtag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flag_set,
    input  logic flag_ack,
    output logic fresh
);

    sem_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SEM_EMPTY: if (flag_set) state_nx = SEM_FRESH;                 // T_ARRIVE
            SEM_FRESH: if (flag_ack && !flag_set) state_nx = SEM_EMPTY;    // T_ACK
            default:   state_nx = SEM_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SEM_EMPTY;
        else     state <= state_nx;
    end

    always_comb begin
        fresh = (state == SEM_FRESH);
    end

    // R8: a write always leaves the flag raised, even alongside an acknowledge
    a_r8_write_keeps_flag: assert property (@(posedge clk) disable iff (rst)
        flag_set |=> fresh);
    // R10: without an acknowledge or a write, the flag holds
    a_r10_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (!flag_set && !flag_ack) |=> fresh == $past(fresh));

endmodule

// File: rtl/semtag_counter.sv
module semtag_counter
    import semtag_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [2:0]       cmd,
    output logic [WIDTH-1:0] value,
    output logic             fresh
);

    act_e act;
    logic flag_set;
    logic flag_ack;

    semtag_decode i_decode (
        .wr_en    (wr_en),
        .cmd      (cmd),
        .act      (act),
        .flag_set (flag_set),
        .flag_ack (flag_ack)
    );

    semtag_value #(.WIDTH(WIDTH)) i_value (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .wr_data (wr_data),
        .q       (value)
    );

    semtag_flag i_flag (
        .clk      (clk),
        .rst      (rst),
        .flag_set (flag_set),
        .flag_ack (flag_ack),
        .fresh    (fresh)
    );

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (value == '0) && !fresh);
    // R2 / R7: a write wins over every command
    a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (value == $past(wr_data)) && fresh);
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && cmd == 3'd4) |=> !fresh && $stable(value));
    a_r9_idle_codes: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && (cmd == 3'd0 || cmd > 3'd4)) |=> $stable(value) && $stable(fresh));

endmodule

// File: tb/test_semtag_counter.sv
`timescale 1ns/1ps
module test_semtag_counter;

    localparam int W = 8;
    localparam logic [W-1:0] ALL1 = '1;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [W-1:0] wr_data;
    logic [2:0]   cmd;
    logic [W-1:0] value;
    logic         fresh;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] m_val;
    logic         m_fresh;

    always #2.5 clk = ~clk;

    semtag_counter #(.WIDTH(W)) i_semtag_counter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .cmd(cmd), .value(value), .fresh(fresh)
    );

    function automatic logic [W-1:0] next_val(input logic r, input logic we,
            input logic [W-1:0] d, input logic [2:0] c, input logic [W-1:0] v);
        if (r)          return '0;
        if (we)         return d;
        if (c == 3'd1)  return '0;
        if (c == 3'd2)  return v + 1'b1;
        if (c == 3'd3)  return v - 1'b1;
        return v;
    endfunction

    function automatic logic next_fresh(input logic r, input logic we,
            input logic [2:0] c, input logic f);
        if (r)          return 1'b0;
        if (we)         return 1'b1;
        if (c == 3'd4)  return 1'b0;
        return f;
    endfunction

    function automatic string tag_of(input logic r, input logic we, input logic [2:0] c);
        if (r)  return "R1";
        if (we) return (c == 3'd4) ? "R8" : ((c != 3'd0 && c < 3'd4) ? "R7" : "R2");
        case (c)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R9/R10";
        endcase
    endfunction

    task automatic step(input logic r, input logic we, input logic [W-1:0] d,
                        input logic [2:0] c);
        string t;
        rst = r; wr_en = we; wr_data = d; cmd = c;
        t = tag_of(r, we, c);
        m_val   = next_val(r, we, d, c, m_val);
        m_fresh = next_fresh(r, we, c, m_fresh);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (value !== m_val || fresh !== m_fresh) begin
            fails++;
            $display("FAIL %s: value=%0h fresh=%0b expected value=%0h fresh=%0b",
                     t, value, fresh, m_val, m_fresh);
        end
    endtask

    initial begin
        int s;
        s = $urandom(32'd1234);
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; cmd = 3'd0;
        m_val = '0; m_fresh = 1'b0;
        @(negedge clk);
        step(1, 0, 8'h00, 3'd0);             // R1 reset state
        step(1, 1, 8'h5a, 3'd2);             // R1 reset beats a write
        step(0, 1, 8'h5a, 3'd0);             // R2 plain write
        step(0, 0, 8'h00, 3'd2);             // R4 count up, flag kept (R10)
        step(0, 0, 8'h00, 3'd4);             // R6 acknowledge
        step(0, 0, 8'h00, 3'd5);             // R9 unused code
        step(0, 0, 8'h00, 3'd6);             // R9
        step(0, 0, 8'h00, 3'd7);             // R9
        step(0, 1, ALL1,  3'd0);             // R2 load all-ones
        step(0, 0, 8'h00, 3'd2);             // R4 wrap to zero
        step(0, 0, 8'h00, 3'd3);             // R5 wrap to all-ones
        step(0, 0, 8'h00, 3'd4);             // R6
        step(0, 1, 8'h33, 3'd4);             // R8 write with acknowledge
        step(0, 1, 8'h44, 3'd1);             // R7 write beats zero
        step(0, 1, 8'h45, 3'd3);             // R7 write beats down
        step(0, 0, 8'h00, 3'd1);             // R3 zero keeps flag
        step(0, 0, 8'h00, 3'd3);             // R5 down from zero
        for (int i = 0; i < 3000; i++) begin
            logic         r;
            logic         we;
            logic [W-1:0] d;
            logic [2:0]   c;
            r  = ($urandom_range(0, 63) == 0);
            we = ($urandom_range(0, 3) == 0);
            case ($urandom_range(0, 3))
                0: d = '0;
                1: d = ALL1;
                default: d = W'($urandom);
            endcase
            c = 3'($urandom_range(0, 7));
            step(r, we, d, c);
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule